// File: doc/BRIEF.md
# ADC Channel Sequencer with Sample FIFO

This block walks a programmed table of conversion entries. Each entry names an analog multiplexer channel and a sampling delay. For each entry, the block drives the channel select, waits the delay in conversion-clock ticks, and then triggers a conversion on a fixed-latency converter model. Each result goes into a receive FIFO. Software takes results out one at a time through a sample read register.

A receive interrupt rises when the FIFO fill reaches a programmed threshold. While that interrupt is pending, the sequencer starts no new entry. An error interrupt rises when a result arrives at a full FIFO. A single-shot pass stops after the last entry and waits for a resume command. A repetitive run wraps back to entry 0. Everything is controlled through a plain word-addressed register port: writes take effect on the clock edge and reads are combinational.

Register word addresses: 0 settings, 1 command (write-only pulses), 2 table write, 3 clock divider, 4 sample (read), 5 status (read).

Top module: `adc_seq_engine`

## Requirements
- R1: After reset, both interrupts, conv_trig_o and mux_sel_o are low, and the status and sample registers read 0.
- R2: A table write packs two entries into one word: the even entry as channel [4:0] and delay [15:5], the odd entry as channel [20:16] and delay [31:21]. Each write stores at the table pointer and advances it by two entries. Command bit 0 returns the pointer to entry 0. mux_sel_o holds steady except when an entry is loaded.
- R3: Settings [21:16] hold the entry count minus one. A pass triggers entries 0 through count-1 in order, with mux_sel_o showing each entry's channel while its trigger pulses.
- R4: The conversion clock ticks once every max(D,1) system cycles, where D is divider register bits [15:0]. An entry's trigger comes on the (delay+1)-th tick after the entry loads, so each extra delay unit adds exactly D cycles.
- R5: With settings bit 13 = 0 (single-shot), the sequencer stops after the last entry. Command bit 1 (start) is then ignored until command bit 2 (resume). Status bit 11 shows the stopped state.
- R6: With settings bit 13 = 1 (repetitive), the entry after the last one is entry 0.
- R7: Each result is {channel[4:0], conversion count[10:0]}, where the count numbers triggers from reset starting at 0. Results enter the FIFO in trigger order. Command bit 6 (pop) moves the FIFO head into the sample register. A pop on an empty FIFO leaves the sample register unchanged.
- R8: rx_irq_o (status bit 8) sets when a stored result brings the fill to settings [29:24] + 1. While it is set, no new entry is loaded. Command bit 3 (clear-data) clears it.
- R9: A result arriving at a full FIFO is dropped and sets err_irq_o (status bit 9). Command bit 4 clears err_irq_o.
- R10: Command bit 5 empties the FIFO, so the fill level (status [7:0]) reads 0.
- R11: A start command while a pass is in progress is ignored.
- R12: The settings register stores sample width [4:0], capture edge bit 6, output mode bit 7, serial delay [12:8], bit 13 and the two 6-bit count fields, and reads them back unchanged. Every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mux_sel_o | output | 5 | Analog multiplexer channel select |
| conv_trig_o | output | 1 | One-cycle conversion trigger |
| rx_irq_o | output | 1 | Receive threshold interrupt |
| err_irq_o | output | 1 | FIFO overflow error interrupt |

## Verification
The bench builds the block with an eight-entry table, a four-deep FIFO and a two-cycle converter latency. With a four-deep FIFO, a repetitive run with an unreachable threshold overflows after its fifth result. A threshold of three, which fits within that depth, shows the pause and release around clear-data. The eight-entry table is small enough that rewriting only the first word after a pointer reset leaves a known older entry in place. A divider of three makes the per-unit delay cost visible as a fixed 12-cycle difference between trigger gaps.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CH_W   = 5;
  localparam int DLY_W  = 11;
  localparam int CNT_W  = 11;
  localparam int DATA_W = CH_W + CNT_W;

  // register word addresses
  localparam logic [2:0] A_CFG    = 3'd0;
  localparam logic [2:0] A_CMD    = 3'd1;
  localparam logic [2:0] A_TABLE  = 3'd2;
  localparam logic [2:0] A_DIV    = 3'd3;
  localparam logic [2:0] A_SAMPLE = 3'd4;
  localparam logic [2:0] A_STATUS = 3'd5;

  // command bits
  localparam int C_PTR_RST   = 0;
  localparam int C_START     = 1;
  localparam int C_RESUME    = 2;
  localparam int C_CLR_DATA  = 3;
  localparam int C_FLUSH_ERR = 4;
  localparam int C_FLUSH     = 5;
  localparam int C_POP       = 6;

  // settings fields
  localparam int          CFG_RPT   = 13;
  localparam int          CFG_CNT   = 16;
  localparam int          CFG_THR   = 24;
  localparam logic [31:0] CFG_MASK  = 32'h3F3F_3FDF;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_DELAY, S_WAIT, S_DONE
  } seq_state_e;
endpackage

// File: rtl/adc_seq_table.sv
// Entry table, two entries per word; NUM_ENTRIES must be a power of two >= 4.
module adc_seq_table #(
  parameter int NUM_ENTRIES = 64,
  localparam int IDX_W  = $clog2(NUM_ENTRIES),
  localparam int WORDS  = NUM_ENTRIES / 2,
  localparam int WPTR_W = $clog2(WORDS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic [31:0]                   wdata_i,
  input  logic                          ptr_rst_i,
  input  logic [IDX_W-1:0]              rd_idx_i,
  output logic [adc_seq_pkg::CH_W-1:0]  rd_ch_o,
  output logic [adc_seq_pkg::DLY_W-1:0] rd_dly_o
);
  logic [31:0]       mem_q [WORDS];
  logic [WPTR_W-1:0] wptr_q;
  logic [31:0]       word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wptr_q <= '0;
    else if (ptr_rst_i) wptr_q <= '0;
    else if (wr_i)      wptr_q <= wptr_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_i && !ptr_rst_i) mem_q[wptr_q] <= wdata_i;
  end

  assign word     = mem_q[rd_idx_i[IDX_W-1:1]];
  assign rd_ch_o  = rd_idx_i[0] ? word[20:16] : word[4:0];
  assign rd_dly_o = rd_idx_i[0] ? word[31:21] : word[15:5];
endmodule

// File: rtl/adc_conv_stub.sv
// Fixed-latency converter model: result = {channel, trigger count}.
module adc_conv_stub #(
  parameter int LAT = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           trig_i,
  input  logic [adc_seq_pkg::CH_W-1:0]   ch_i,
  output logic                           valid_o,
  output logic [adc_seq_pkg::DATA_W-1:0] data_o
);
  import adc_seq_pkg::*;
  logic [LAT-1:0]    vpipe_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      data_q <= '0;
    end else if (trig_i) begin
      cnt_q  <= cnt_q + 1'b1;
      data_q <= {ch_i, cnt_q};
    end
  end

  generate
    if (LAT == 1) begin : g_lat1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) vpipe_q <= '0;
        else         vpipe_q <= trig_i;
      end
    end else begin : g_latn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) vpipe_q <= '0;
        else         vpipe_q <= {vpipe_q[LAT-2:0], trig_i};
      end
    end
  endgenerate

  assign valid_o = vpipe_q[LAT-1];
  assign data_o  = data_q;
endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output logic [W-1:0]     head_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [LVL_W-1:0] level_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [LVL_W-1:0] lvl_q;
  logic             do_push, do_pop;

  assign empty_o = (lvl_q == '0);
  assign full_o  = (lvl_q == LVL_W'(DEPTH));
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      if (do_push && !do_pop)      lvl_q <= lvl_q + 1'b1;
      else if (do_pop && !do_push) lvl_q <= lvl_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= data_i;
  end

  assign head_o  = mem_q[rptr_q];
  assign level_o = lvl_q;

  // R9
  drop_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> $stable(level_o));
  // R10
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (level_o == '0));
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm #(
  parameter int IDX_W = 6,
  parameter int DIV_W = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic                          resume_i,
  input  logic                          repeat_i,
  input  logic                          hold_i,
  input  logic [IDX_W-1:0]              last_idx_i,
  input  logic [DIV_W-1:0]              div_ratio_i,
  input  logic [adc_seq_pkg::CH_W-1:0]  ent_ch_i,
  input  logic [adc_seq_pkg::DLY_W-1:0] ent_dly_i,
  input  logic                          res_valid_i,
  output logic [IDX_W-1:0]              rd_idx_o,
  output logic [adc_seq_pkg::CH_W-1:0]  mux_sel_o,
  output logic                          trig_o,
  output logic                          busy_o,
  output logic                          held_o
);
  import adc_seq_pkg::*;
  seq_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CH_W-1:0]   mux_q;
  logic [DLY_W-1:0]  dly_q;
  logic [DIV_W-1:0]  div_q, period_m1;
  logic              trig_q;

  assign period_m1 = (div_ratio_i == '0) ? '0 : div_ratio_i - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      mux_q   <= '0;
      dly_q   <= '0;
      div_q   <= '0;
      trig_q  <= 1'b0;
    end else begin
      trig_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          idx_q   <= '0;
          state_q <= S_LOAD;
        end
        S_LOAD: if (!hold_i) begin
          mux_q   <= ent_ch_i;
          dly_q   <= ent_dly_i;
          div_q   <= '0;
          state_q <= S_DELAY;
        end
        S_DELAY: begin
          if (div_q == period_m1) begin
            div_q <= '0;
            if (dly_q == '0) begin
              trig_q  <= 1'b1;
              state_q <= S_WAIT;
            end else begin
              dly_q <= dly_q - 1'b1;
            end
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        S_WAIT: if (res_valid_i) begin
          if (idx_q == last_idx_i) begin
            idx_q   <= '0;
            state_q <= repeat_i ? S_LOAD : S_DONE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_LOAD;
          end
        end
        S_DONE: if (resume_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rd_idx_o  = idx_q;
  assign mux_sel_o = mux_q;
  assign trig_o    = trig_q;
  assign busy_o    = (state_q == S_LOAD) || (state_q == S_DELAY) || (state_q == S_WAIT);
  assign held_o    = (state_q == S_DONE);

  // R4
  trig_after_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> $past(state_q) == S_DELAY);
  // R2
  mux_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_LOAD) |=> $stable(mux_sel_o));
  // R5
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DONE && !resume_i) |=> state_q == S_DONE);
  // R8
  rx_pause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_LOAD && hold_i) |=> state_q == S_LOAD);
endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine #(
  parameter int NUM_ENTRIES = 64,
  parameter int FIFO_DEPTH  = 16,
  parameter int CONV_LAT    = 4,
  parameter int DIV_W       = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES),
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic [4:0]  mux_sel_o,
  output logic        conv_trig_o,
  output logic        rx_irq_o,
  output logic        err_irq_o
);
  import adc_seq_pkg::*;

  logic [31:0]       cfg_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] sample_q;
  logic              rx_q, err_q;

  logic cmd_we, tbl_we;
  logic c_ptr_rst, c_start, c_resume, c_clr_data, c_flush_err, c_flush, c_pop;

  logic [IDX_W-1:0]  rd_idx, last_idx;
  logic [CH_W-1:0]   ent_ch, mux_sel;
  logic [DLY_W-1:0]  ent_dly;
  logic              trig, busy, held;
  logic              res_valid;
  logic [DATA_W-1:0] res_data, fifo_head;
  logic              fifo_empty, fifo_full;
  logic [LVL_W-1:0]  fifo_level;
  logic [7:0]        lvl8, thr8;
  logic              push_ok;

  assign cmd_we      = reg_we_i && (reg_addr_i == A_CMD);
  assign tbl_we      = reg_we_i && (reg_addr_i == A_TABLE);
  assign c_ptr_rst   = cmd_we && reg_wdata_i[C_PTR_RST];
  assign c_start     = cmd_we && reg_wdata_i[C_START];
  assign c_resume    = cmd_we && reg_wdata_i[C_RESUME];
  assign c_clr_data  = cmd_we && reg_wdata_i[C_CLR_DATA];
  assign c_flush_err = cmd_we && reg_wdata_i[C_FLUSH_ERR];
  assign c_flush     = cmd_we && reg_wdata_i[C_FLUSH];
  assign c_pop       = cmd_we && reg_wdata_i[C_POP];

  assign last_idx = IDX_W'(cfg_q[CFG_CNT +: 6]);
  assign lvl8     = 8'(fifo_level);
  assign thr8     = {2'b00, cfg_q[CFG_THR +: 6]} + 8'd1;
  assign push_ok  = res_valid && !fifo_full && !c_flush;

  adc_seq_table #(.NUM_ENTRIES(NUM_ENTRIES)) u_table (
    .clk_i, .rst_ni,
    .wr_i      (tbl_we),
    .wdata_i   (reg_wdata_i),
    .ptr_rst_i (c_ptr_rst),
    .rd_idx_i  (rd_idx),
    .rd_ch_o   (ent_ch),
    .rd_dly_o  (ent_dly)
  );

  adc_seq_fsm #(.IDX_W(IDX_W), .DIV_W(DIV_W)) u_fsm (
    .clk_i, .rst_ni,
    .start_i     (c_start),
    .resume_i    (c_resume),
    .repeat_i    (cfg_q[CFG_RPT]),
    .hold_i      (rx_q),
    .last_idx_i  (last_idx),
    .div_ratio_i (div_q),
    .ent_ch_i    (ent_ch),
    .ent_dly_i   (ent_dly),
    .res_valid_i (res_valid),
    .rd_idx_o    (rd_idx),
    .mux_sel_o   (mux_sel),
    .trig_o      (trig),
    .busy_o      (busy),
    .held_o      (held)
  );

  adc_conv_stub #(.LAT(CONV_LAT)) u_conv (
    .clk_i, .rst_ni,
    .trig_i  (trig),
    .ch_i    (mux_sel),
    .valid_o (res_valid),
    .data_o  (res_data)
  );

  adc_sample_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
    .clk_i, .rst_ni,
    .push_i  (res_valid),
    .data_i  (res_data),
    .pop_i   (c_pop),
    .flush_i (c_flush),
    .head_o  (fifo_head),
    .empty_o (fifo_empty),
    .full_o  (fifo_full),
    .level_o (fifo_level)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      div_q    <= '0;
      sample_q <= '0;
      rx_q     <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (reg_we_i && reg_addr_i == A_CFG) cfg_q <= reg_wdata_i & CFG_MASK;
      if (reg_we_i && reg_addr_i == A_DIV) div_q <= reg_wdata_i[DIV_W-1:0];
      if (c_pop && !fifo_empty && !c_flush) sample_q <= fifo_head;
      // set wins over a same-cycle clear
      if (push_ok && (lvl8 + 8'd1 >= thr8)) rx_q <= 1'b1;
      else if (c_clr_data)                  rx_q <= 1'b0;
      if (res_valid && fifo_full && !c_flush) err_q <= 1'b1;
      else if (c_flush_err)                   err_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      A_CFG:    reg_rdata_o = cfg_q;
      A_DIV:    reg_rdata_o = 32'(div_q);
      A_SAMPLE: reg_rdata_o = 32'(sample_q);
      A_STATUS: reg_rdata_o = {20'd0, held, busy, err_q, rx_q, lvl8};
      default:  reg_rdata_o = '0;
    endcase
  end

  assign mux_sel_o   = mux_sel;
  assign conv_trig_o = trig;
  assign rx_irq_o    = rx_q;
  assign err_irq_o   = err_q;

  // R9
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_irq_o) |-> $past(fifo_full) && $past(res_valid));
  // R8
  rx_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_irq_o) |-> ($past(lvl8) + 8'd1 >= $past(thr8)));
  // R3
  trig_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_trig_o |=> !conv_trig_o);
endmodule

// File: tb/sim_adc_seq_engine.sv
module sim_adc_seq_engine;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4:0]  mux_sel;
  logic        trig, rx_irq, err_irq;

  int n_chk = 0, n_fail = 0, cyc = 0, n_trig = 0;
  bit done = 1'b0;
  logic [4:0]  exp_ch[$];
  logic [15:0] exp_data[$];
  int          trig_t[$];
  logic [10:0] conv_cnt = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_seq_engine #(.NUM_ENTRIES(8), .FIFO_DEPTH(4), .CONV_LAT(2)) u0 (
    .clk_i(clk), .rst_ni, .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .mux_sel_o(mux_sel), .conv_trig_o(trig),
    .rx_irq_o(rx_irq), .err_irq_o(err_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: trigger scoreboard (R2/R3 channel order, R7 result model)
  always @(negedge clk) begin
    if (rst_ni && trig) begin
      n_trig++;
      trig_t.push_back(cyc);
      n_chk++;
      if (exp_ch.size() == 0) begin
        n_fail++;
        $display("FAIL R3: actual trigger ch %0d expected no trigger", mux_sel);
      end else begin
        logic [4:0] e;
        e = exp_ch.pop_front();
        if (mux_sel !== e) begin
          n_fail++;
          $display("FAIL R3: actual ch %0d expected %0d", mux_sel, e);
        end
      end
      exp_data.push_back({mux_sel, conv_cnt});
      conv_cnt = conv_cnt + 1'b1;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(input int bitpos);
    wr(3'd1, 32'h1 << bitpos);
  endtask

  task automatic pop_chk(input string req);
    logic [31:0] v;
    logic [15:0] e;
    cmd(6);
    rd(3'd4, v);
    e = (exp_data.size() != 0) ? exp_data.pop_front() : 16'hxxxx;
    chk(req, v, {16'd0, e});
  endtask

  function automatic logic [31:0] cfg(input bit rpt, input int cnt, input int thr);
    return (32'(thr - 1) << 24) | (32'(cnt - 1) << 16) | (32'(rpt) << 13);
  endfunction

  function automatic logic [31:0] pair(input int c0, input int d0, input int c1, input int d1);
    return (32'(d1) << 21) | (32'(c1) << 16) | (32'(d0) << 5) | 32'(c0);
  endfunction

  initial begin
    logic [31:0] v, last;
    int base;
    wait_cyc(4);
    rst_ni = 1'b1;
    wait_cyc(2);

    // R1 reset state
    rd(3'd5, v); chk("R1 status", v, 0);
    rd(3'd4, v); chk("R1 sample", v, 0);
    chk("R1 irqs/trig", {rx_irq, err_irq, trig}, 0);
    chk("R1 mux", 32'(mux_sel), 0);

    // R12 settings readback
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R12 cfg mask", v, 32'h3F3F_3FDF);
    wr(3'd0, 32'h0000_1AD5);
    rd(3'd0, v); chk("R12 cfg fields", v, 32'h0000_1AD5 & 32'h3F3F_3FDF);

    // R2 R3 R5 R11: single-shot, three entries
    wr(3'd3, 32'd1);
    wr(3'd0, cfg(0, 3, 8));
    cmd(0);
    wr(3'd2, pair(5, 0, 9, 2));
    wr(3'd2, pair(17, 1, 31, 0));
    exp_ch.push_back(5); exp_ch.push_back(9); exp_ch.push_back(17);
    cmd(1);
    wait_cyc(3);
    cmd(1);                         // R11 start while running
    wait_cyc(100);
    chk("R11 trig count", n_trig, 3);
    chk("R3 all entries run", exp_ch.size(), 0);
    rd(3'd5, v);
    chk("R3 level", v[7:0], 3);
    chk("R5 held", v[11], 1);
    cmd(1);                         // R5 start ignored while held
    wait_cyc(60);
    chk("R5 no retrigger", n_trig, 3);
    pop_chk("R7 pop0"); pop_chk("R7 pop1"); pop_chk("R7 pop2");
    rd(3'd4, last);
    cmd(6);                         // R7 pop on empty
    rd(3'd4, v); chk("R7 empty pop", v, last);

    // R2 pointer reset: rewrite word 0 only; entry 2 stays
    cmd(2);
    cmd(0);
    wr(3'd2, pair(12, 0, 13, 0));
    exp_ch.push_back(12); exp_ch.push_back(13); exp_ch.push_back(17);
    cmd(1);
    wait_cyc(100);
    chk("R2 ptr reset entries", n_trig, 6);
    chk("R2 queue drained", exp_ch.size(), 0);
    rd(3'd5, v); chk("R10 level before flush", v[7:0], 3);
    cmd(5);
    rd(3'd5, v); chk("R10 flush", v[7:0], 0);
    exp_data.delete();
    cmd(2);

    // R4 delay timing, divider = 3
    wr(3'd3, 32'd3);
    cmd(0);
    wr(3'd2, pair(1, 0, 2, 4));
    wr(3'd2, pair(3, 0, 0, 0));
    exp_ch.push_back(1); exp_ch.push_back(2); exp_ch.push_back(3);
    trig_t.delete();
    cmd(1);
    wait_cyc(200);
    chk("R4 trig count", trig_t.size(), 3);
    if (trig_t.size() == 3)
      chk("R4 delay cost", (trig_t[1] - trig_t[0]) - (trig_t[2] - trig_t[1]), 12);
    cmd(5);
    exp_data.delete();
    cmd(2);

    // R6 R8 repetitive with threshold 3
    wr(3'd3, 32'd1);
    wr(3'd0, cfg(1, 2, 3));
    cmd(0);
    wr(3'd2, pair(3, 0, 4, 1));
    exp_ch.push_back(3); exp_ch.push_back(4); exp_ch.push_back(3);
    base = n_trig;
    cmd(1);
    wait_cyc(100);
    chk("R8 rx set", rx_irq, 1);
    chk("R8 paused", n_trig - base, 3);
    chk("R6 wrap order", exp_ch.size(), 0);
    rd(3'd5, v); chk("R8 level", v[7:0], 3);
    pop_chk("R7 rep pop0"); pop_chk("R7 rep pop1"); pop_chk("R7 rep pop2");
    chk("R8 rx sticky", rx_irq, 1);
    exp_ch.push_back(4); exp_ch.push_back(3); exp_ch.push_back(4);
    cmd(3);
    wait_cyc(100);
    chk("R8 resumed", n_trig - base, 6);
    chk("R8 rx again", rx_irq, 1);
    pop_chk("R6 pop0"); pop_chk("R6 pop1"); pop_chk("R6 pop2");

    // R9 overflow, threshold unreachable
    for (int i = 0; i < 10; i++) begin
      exp_ch.push_back(3); exp_ch.push_back(4);
    end
    wr(3'd0, cfg(1, 2, 8));
    cmd(3);
    wait_cyc(40);
    wr(3'd0, cfg(0, 2, 8));
    wait_cyc(60);
    chk("R9 err set", err_irq, 1);
    chk("R8 rx clear", rx_irq, 0);
    rd(3'd5, v); chk("R9 level full", v[7:0], 4);
    pop_chk("R9 kept0"); pop_chk("R9 kept1"); pop_chk("R9 kept2"); pop_chk("R9 kept3");
    exp_ch.delete();
    exp_data.delete();
    cmd(5);
    cmd(4);
    wait_cyc(2);
    chk("R9 err cleared", err_irq, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule